// File: doc/BRIEF.md
# Opcode Fetch Burst Sequencer

This block fetches a single script instruction from memory when the instruction prefetch path is turned off. It accepts a fetch start that carries the instruction pointer. It then issues one or more bus-ownership requests, each made of a start byte address and a dword count, and gathers the returned dwords into an instruction register. The upper opcode bits of the first dword set the instruction's class. The class fixes how many dwords the instruction has and how they are split across separate bus ownerships. When the last dword has arrived, the block pulses `done`. The assembled instruction, its length and the advanced instruction pointer are valid at the same time as that pulse.

When burst opcode fetch is on, the first two dwords always come in one two-dword burst. The remaining dwords follow in later ownerships, with at most two dwords in each. When burst opcode fetch is off, every dword gets its own single-dword ownership. While prefetching is enabled the sequencer is bypassed: it refuses starts and issues nothing.

The start, request and read-data paths are valid/ready streams. A transfer happens on a rising clock edge where both valid and ready are high. The block holds a pending request steady for as long as `req_ready` stays low. The bus may hold back read data by keeping `rd_valid` low. `rd_ready` is high only while the block is waiting for dwords of an ownership that has already been granted. Arbitration and full instruction decoding are not part of this block.

Top module: `opfetch_burst_seq`

## Requirements
- R1: `start_ready` is 1 only while the block is idle and `prefetch_en` is 0. A start handshake latches `start_addr` as the instruction pointer and samples `burst_en` for the whole fetch.
- R2: While `prefetch_en` is 1, `start_valid` is ignored. No request is issued and `done` stays 0.
- R3: With burst fetch on, the first ownership after a start asks for `req_len`=2 at the instruction pointer. No request ever asks for more than 2 dwords.
- R4: The class comes from the top four bits b3..b0 of dword 0 (bits 31..28). b3b2=11 is a memory move (3 dwords). b3b2=00 with b1=1 is table-indirect (4 dwords). b3b2=00 with b1=0 and b0=1 is indirect (3 dwords). Every other value is a plain instruction (2 dwords).
- R5: In burst mode, a memory move fetches dword 2 in a second ownership of length 1 at pointer+8.
- R6: In burst mode, an indirect instruction fetches its extra dword in a second ownership of length 1 at pointer+8.
- R7: In burst mode, a table-indirect instruction uses two ownerships of length 2, at the pointer and at pointer+8. The table-indirect bit takes priority over the indirect bit.
- R8: With burst fetch off, every dword k is fetched in its own ownership of length 1 at pointer+4k.
- R9: A request whose `req_ready` is 0 stays asserted, with the same address and length, until it is accepted.
- R10: `rd_ready` is 1 only after a request has been accepted and before all of its dwords have arrived. Cycles where `rd_valid` is 0 do not advance the fetch. Request, read-data, done and start-ready are never active in the same cycle.
- R11: `done` is high for exactly one cycle, the cycle right after the last dword is accepted. `instr` then holds dword k in bits [32k+31:32k], with unused words at zero. `instr_len` gives the dword count.
- R12: While `done` is high, `next_ip` equals the instruction pointer plus 4 times the dword count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prefetch_en | input | 1 | Prefetch path active; sequencer bypassed |
| burst_en | input | 1 | Burst opcode fetch enable, sampled at start |
| start_valid | input | 1 | Fetch start request |
| start_ready | output | 1 | Ready to accept a fetch start |
| start_addr | input | AW | Instruction pointer (byte address) |
| req_valid | output | 1 | Bus-ownership request valid |
| req_ready | input | 1 | Bus-ownership request accepted |
| req_addr | output | AW | Start byte address of the ownership |
| req_len | output | LENW | Dword count of the ownership |
| rd_valid | input | 1 | Returned dword valid |
| rd_ready | output | 1 | Block accepts a returned dword |
| rd_data | input | DW | Returned dword |
| done | output | 1 | One-cycle fetch completion pulse |
| instr | output | MAX_DW*DW | Assembled instruction, dword 0 in the low bits |
| instr_len | output | LENW | Dwords in the assembled instruction |
| next_ip | output | AW | Advanced instruction pointer |

## Verification
Two functions can fall in the same cycle. The first is the acceptance of the first dword, which triggers type classification from `rd_data`. The second is the decision whether the current ownership has ended and whether another one must follow. In non-burst mode both happen on the same edge. The bench provokes this by sending memory-move, indirect and table-indirect first dwords with burst off. The next request's address and length show whether the class decoded in that cycle was used. Request back-pressure and idle read cycles are also mixed in, so the bench can see that a stalled request stays stable and that `done` comes exactly one cycle after the final beat.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } opf_state_e;
endpackage

// File: rtl/opf_type_decode.sv
module opf_type_decode #(
  parameter int LENW = 3
) (
  input  logic [3:0]      op_bits,
  output logic [LENW-1:0] total_dw
);
  // op_bits = dword0[31:28]; table-indirect outranks indirect
  always_comb begin
    if (op_bits[3:2] == 2'b11)
      total_dw = LENW'(3);
    else if (op_bits[3:2] == 2'b00 && op_bits[1])
      total_dw = LENW'(4);
    else if (op_bits[3:2] == 2'b00 && op_bits[0])
      total_dw = LENW'(3);
    else
      total_dw = LENW'(2);
  end
endmodule

// File: rtl/opf_group_len.sv
module opf_group_len #(
  parameter int LENW     = 3,
  parameter int BURST_DW = 2
) (
  input  logic            burst,
  input  logic [LENW-1:0] remaining,
  output logic [LENW-1:0] grp_len
);
  localparam logic [LENW-1:0] BurstCap = LENW'(BURST_DW);

  always_comb begin
    if (!burst)
      grp_len = LENW'(1);
    else if (remaining > BurstCap)
      grp_len = BurstCap;
    else
      grp_len = remaining;
  end
endmodule

// File: rtl/opf_instr_store.sv
module opf_instr_store #(
  parameter int DW     = 32,
  parameter int MAX_DW = 4,
  localparam int IDXW  = $clog2(MAX_DW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic [DW-1:0]        wr_data,
  output logic [MAX_DW*DW-1:0] instr
);
  for (genvar g = 0; g < MAX_DW; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (clr)
        word_q <= '0;
      else if (wr_en && wr_idx == IDXW'(g))
        word_q <= wr_data;
    end
    assign instr[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/opfetch_burst_seq.sv
module opfetch_burst_seq
  import opf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int MAX_DW   = 4,
  parameter int BURST_DW = 2,
  localparam int LENW    = $clog2(MAX_DW + 1),
  localparam int IDXW    = $clog2(MAX_DW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prefetch_en,
  input  logic                 burst_en,
  input  logic                 start_valid,
  output logic                 start_ready,
  input  logic [AW-1:0]        start_addr,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [AW-1:0]        req_addr,
  output logic [LENW-1:0]      req_len,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [DW-1:0]        rd_data,
  output logic                 done,
  output logic [MAX_DW*DW-1:0] instr,
  output logic [LENW-1:0]      instr_len,
  output logic [AW-1:0]        next_ip
);
  localparam int PADW = AW - LENW - 2;

  opf_state_e      state_q;
  logic [AW-1:0]   ip_q;
  logic            burst_q;
  logic [LENW-1:0] total_q;
  logic [LENW-1:0] got_q;
  logic [LENW-1:0] left_q;
  logic [LENW-1:0] dec_total;
  logic [LENW-1:0] total_eff;
  logic [LENW-1:0] grp_len;

  logic start_fire, req_fire, rd_fire;

  assign start_ready = (state_q == ST_IDLE) && !prefetch_en;
  assign start_fire  = start_valid && start_ready;
  assign req_valid   = (state_q == ST_REQ);
  assign req_fire    = req_valid && req_ready;
  assign rd_ready    = (state_q == ST_DATA);
  assign rd_fire     = rd_valid && rd_ready;
  assign done        = (state_q == ST_DONE);

  opf_type_decode #(.LENW(LENW)) u_dec (
    .op_bits  (rd_data[DW-1 -: 4]),
    .total_dw (dec_total)
  );

  opf_group_len #(.LENW(LENW), .BURST_DW(BURST_DW)) u_grp (
    .burst     (burst_q),
    .remaining (total_q - got_q),
    .grp_len   (grp_len)
  );

  opf_instr_store #(.DW(DW), .MAX_DW(MAX_DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_fire),
    .wr_en   (rd_fire),
    .wr_idx  (got_q[IDXW-1:0]),
    .wr_data (rd_data),
    .instr   (instr)
  );

  // class is known on the first beat; later beats use the stored count
  assign total_eff = (got_q == '0) ? dec_total : total_q;

  assign req_addr  = ip_q + {{PADW{1'b0}}, got_q, 2'b00};
  assign req_len   = grp_len;
  assign instr_len = total_q;
  assign next_ip   = ip_q + {{PADW{1'b0}}, total_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ip_q    <= '0;
      burst_q <= 1'b0;
      total_q <= '0;
      got_q   <= '0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_fire) begin
            ip_q    <= start_addr;
            burst_q <= burst_en;
            total_q <= LENW'(2);
            got_q   <= '0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_fire) begin
            left_q  <= grp_len;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (rd_fire) begin
            got_q   <= got_q + LENW'(1);
            total_q <= total_eff;
            left_q  <= left_q - LENW'(1);
            if (left_q == LENW'(1)) begin
              if (got_q + LENW'(1) == total_eff)
                state_q <= ST_DONE;
              else
                state_q <= ST_REQ;
            end
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opf_seq_chk.sv
module opf_seq_chk #(
  parameter int AW       = 32,
  parameter int LENW     = 3,
  parameter int BURST_DW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            prefetch_en,
  input logic            start_ready,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic [LENW-1:0] req_len,
  input logic            rd_ready,
  input logic            done,
  input logic [LENW-1:0] instr_len,
  input logic            burst_q
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));

  a_r8_single_len: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !burst_q |-> req_len == LENW'(1));

  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len >= LENW'(1) && req_len <= LENW'(BURST_DW));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> instr_len >= LENW'(2) && instr_len <= LENW'(4));

  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_en |-> !start_ready);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, rd_ready, done, start_ready}));
endmodule

bind opfetch_burst_seq opf_seq_chk #(.AW(AW), .LENW(LENW), .BURST_DW(BURST_DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prefetch_en (prefetch_en),
  .start_ready (start_ready),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_len     (req_len),
  .rd_ready    (rd_ready),
  .done        (done),
  .instr_len   (instr_len),
  .burst_q     (burst_q)
);

// File: tb/opfetch_burst_seq_tb.sv
module opfetch_burst_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         prefetch_en = 1'b0;
  logic         burst_en = 1'b0;
  logic         start_valid = 1'b0;
  logic         start_ready;
  logic [31:0]  start_addr = '0;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [31:0]  req_addr;
  logic [2:0]   req_len;
  logic         rd_valid = 1'b0;
  logic         rd_ready;
  logic [31:0]  rd_data = '0;
  logic         done;
  logic [127:0] instr;
  logic [2:0]   instr_len;
  logic [31:0]  next_ip;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  opfetch_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .prefetch_en(prefetch_en), .burst_en(burst_en),
    .start_valid(start_valid), .start_ready(start_ready), .start_addr(start_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .instr(instr), .instr_len(instr_len), .next_ip(next_ip)
  );

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // R4 class table, from the top four bits of dword 0
  function automatic int exp_total(input logic [31:0] w0);
    if (w0[31:30] == 2'b11) return 3;
    if (w0[31:30] == 2'b00 && w0[29]) return 4;
    if (w0[31:30] == 2'b00 && w0[28]) return 3;
    return 2;
  endfunction

  task automatic do_fetch(input logic [31:0] ip, input logic bm,
                          input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3,
                          input int stall, input bit gap, input string tg);
    logic [31:0]  w [4];
    logic [127:0] exp_i;
    int tot, got, glen;
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    tot = exp_total(w0);
    exp_i = '0;
    for (int k = 0; k < tot; k++) exp_i[k*32 +: 32] = w[k];
    burst_en = bm; start_addr = ip; start_valid = 1'b1;
    chk(start_ready == 1'b1, {"R1 start_ready idle ", tg}, start_ready, 1);
    @(negedge clk);
    start_valid = 1'b0;
    burst_en = ~bm;  // R1: mode sampled at start only
    got = 0;
    while (got < tot) begin
      glen = bm ? (((tot - got) > 2) ? 2 : (tot - got)) : 1;
      chk(req_valid == 1'b1, {"R3/R5/R6/R7/R8 req_valid ", tg}, req_valid, 1);
      chk(req_addr == ip + 32'(4 * got), {"R5/R6/R7/R8 req_addr ", tg}, req_addr, ip + 32'(4 * got));
      chk(req_len == 3'(glen), {"R3/R5/R6/R7/R8 req_len ", tg}, req_len, glen);
      chk(start_ready == 1'b0, {"R1 busy ", tg}, start_ready, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(req_valid && req_addr == ip + 32'(4 * got) && req_len == 3'(glen),
            {"R9 held request ", tg}, {req_valid, req_len, req_addr}, {1'b1, 3'(glen), ip + 32'(4 * got)});
      end
      chk(rd_ready == 1'b0, {"R10 no rd_ready before grant ", tg}, rd_ready, 0);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      for (int b = 0; b < glen; b++) begin
        if (gap) begin
          @(negedge clk);
          chk(rd_ready == 1'b1 && req_valid == 1'b0, {"R10 idle beat ", tg}, {rd_ready, req_valid}, 2'b10);
        end
        rd_valid = 1'b1; rd_data = w[got];
        @(negedge clk);
        rd_valid = 1'b0;
        got++;
        if (got < tot && b == glen - 1)
          chk(done == 1'b0, {"R11 no early done ", tg}, done, 0);
      end
    end
    chk(done == 1'b1, {"R11 done after last beat ", tg}, done, 1);
    chk(instr == exp_i, {"R11 instr ", tg}, instr, exp_i);
    chk(instr_len == 3'(tot), {"R4/R11 instr_len ", tg}, instr_len, tot);
    chk(next_ip == ip + 32'(4 * tot), {"R12 next_ip ", tg}, next_ip, ip + 32'(4 * tot));
    @(negedge clk);
    chk(done == 1'b0 && req_valid == 1'b0, {"R11 done one cycle ", tg}, {done, req_valid}, 0);
  endtask

  task automatic t_reset();
    chk(start_ready == 1'b1, "R1 reset start_ready", start_ready, 1);
    chk(req_valid == 1'b0 && rd_ready == 1'b0 && done == 1'b0, "R10 reset idle",
        {req_valid, rd_ready, done}, 0);
    chk(instr == '0 && instr_len == '0, "R11 reset instr", instr, 0);
  endtask

  task automatic t_bypass();
    prefetch_en = 1'b1; start_valid = 1'b1; start_addr = 32'h0000_4000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(start_ready == 1'b0 && req_valid == 1'b0 && done == 1'b0, "R2 bypass",
          {start_ready, req_valid, done}, 0);
    end
    start_valid = 1'b0; prefetch_en = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b0 && start_ready == 1'b1, "R2 nothing latched", {req_valid, start_ready}, 1);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    do_fetch(32'h0000_1000, 1'b1, 32'h4A00_0001, 32'h1111_1111, '0, '0, 0, 1'b0, "burst plain");
    do_fetch(32'h0000_2000, 1'b1, 32'hC100_0002, 32'h2222_2222, 32'h3333_3333, '0, 2, 1'b1, "burst memmove");
    do_fetch(32'h0000_3000, 1'b1, 32'h1000_0003, 32'h4444_4444, 32'h5555_5555, '0, 1, 1'b0, "burst indirect");
    do_fetch(32'h0000_3100, 1'b1, 32'h3000_0004, 32'h6666_6666, 32'h7777_7777, 32'h8888_8888, 0, 1'b1, "burst table");
    do_fetch(32'h0000_5000, 1'b0, 32'h2000_0005, 32'h9999_9999, 32'hAAAA_AAAA, 32'hBBBB_BBBB, 1, 1'b0, "single table");
    do_fetch(32'h0000_6000, 1'b0, 32'hF000_0006, 32'hCCCC_CCCC, 32'hDDDD_DDDD, '0, 0, 1'b1, "single memmove");
    do_fetch(32'h0000_7000, 1'b0, 32'h8000_0007, 32'hEEEE_EEEE, '0, '0, 0, 1'b0, "single plain");
    t_bypass();
    do_fetch(32'hFFFF_FFF0, 1'b1, 32'h1800_0008, 32'h0F0F_0F0F, 32'hF0F0_F0F0, '0, 0, 1'b0, "wrap indirect");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule